// File: doc/BRIEF.md
# Synchronous-Mode Handshake Sequencer

This block decides when the clock-domain bridges of a subsystem may bypass their synchronizers. Software programs a performance level, and the sequencer passes a target level on to the voltage and clock-generation logic. It watches the level that the clock generator reports back. Only the highest level runs the processor clock in lock with the system clock. Moving into or out of that level goes through a request/acknowledge exchange with the bridges. Moves between lower levels go straight to the target output.

Entering the top level raises the target first. The request is raised only once the clock generator confirms both the full level and synchronous clocks. Leaving the top level works the other way round: the request drops first, and the lower target is issued only after every bridge has dropped its acknowledge. A transition that has started is always finished before the opposite transition begins. In emulation mode the exchange is switched off. The target then follows the programmed level directly and the acknowledge input is ignored. This lets a tied-high acknowledge coexist with emulation.

Top module: `sync_mode_sequencer`

## Requirements
- R1: After reset the target level equals the parameter RST_LEVEL and the sync request is low.
- R2: With emulation off and the sequencer asynchronous, a programmed level below full that differs from the target appears on the target output one clock later, and the request stays low.
- R3: The full level is the all-ones code of the level field. Programming it while asynchronous drives the target to full one clock later. The request rises only on the clock after the reported level is full and the clocks-synchronous flag is high, both seen together.
- R4: Once raised, the request stays high while the acknowledge is low. An acknowledge seen high completes entry.
- R5: When a level below full is programmed in synchronous mode, the request falls one clock later while the target stays full. The lower target is driven on the second clock after the acknowledge is seen low, and not before.
- R6: A reduction programmed during entry does not lower the request or the target until the acknowledge has gone high. After that the exit sequence of R5 runs.
- R7: While emulation mode is high, the request is low from the clock after it was first seen. The target follows the programmed level one clock later, including the full level, without waiting on the reported level.
- R8: While emulation mode is high, the acknowledge value has no effect: a tied-high acknowledge neither raises the request nor stalls target updates.
- R9: The acknowledge input is the AND of all bridge acknowledges. Entry does not complete while any single bridge still holds its acknowledge low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| progLevel | input | LVL_W | Performance level programmed by software |
| curLevel | input | LVL_W | Level currently reported by the clock generator |
| clkSynced | input | 1 | Clock generator reports processor and system clocks synchronous |
| syncAck | input | 1 | AND of all bridge acknowledges, already synchronized |
| emuMode | input | 1 | Emulation mode: disables the handshake |
| targetLevel | output | LVL_W | Target level to voltage and clock-generation logic |
| syncReq | output | 1 | Request for bridges to enter synchronous mode |

## Verification
The hardest situation to reach from the ports is a reduction that lands while the request is already high and the bridges have not yet answered. If that happens, the sequencer must neither drop the request nor lower the target. The bench gets there with a directed step: it freezes its bridge models, programs full, waits for the request, and then programs a low level. Three bridge models with different random response delays are ANDed together, so the random phase also often catches reductions in the middle of an exchange. A reference model checks every clock against them.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [2:0] {
    IDLE_ASYNC  = 3'd0,
    WAIT_LEVEL  = 3'd1,
    WAIT_ACK_HI = 3'd2,
    SYNC        = 3'd3,
    WAIT_ACK_LO = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadProg;  // copy programmed level into target
    logic loadFull;  // force target to full level
    logic setReq;    // raise bridge request
    logic clrReq;    // drop bridge request
  } dpStrobe_t;

endpackage

// File: rtl/sms_ctrl.sv
module sms_ctrl
  import sms_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] progLevel,
  input  logic [LVL_W-1:0] curLevel,
  input  logic [LVL_W-1:0] targetLevel,
  input  logic             clkSynced,
  input  logic             syncAck,
  input  logic             emuMode,
  output dpStrobe_t        strobe
);

  localparam logic [LVL_W-1:0] FULL_LVL = {LVL_W{1'b1}};

  seqState_t state, stateNxt;
  logic progFull, clockReady;

  assign progFull   = (progLevel == FULL_LVL);
  assign clockReady = (curLevel == FULL_LVL) && clkSynced;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (emuMode) begin
      // handshake disabled: drop request, target tracks program
      strobe.clrReq = 1'b1;
      stateNxt      = IDLE_ASYNC;
      if (state == IDLE_ASYNC && progLevel != targetLevel) strobe.loadProg = 1'b1;
    end else begin
      unique case (state)
        IDLE_ASYNC: begin
          if (progFull) begin
            strobe.loadFull = 1'b1;
            stateNxt        = WAIT_LEVEL;
          end else if (progLevel != targetLevel) begin
            strobe.loadProg = 1'b1;
          end
        end
        WAIT_LEVEL: begin
          if (clockReady) begin
            strobe.setReq = 1'b1;
            stateNxt      = WAIT_ACK_HI;
          end
        end
        WAIT_ACK_HI: begin
          if (syncAck) stateNxt = SYNC;
        end
        SYNC: begin
          if (!progFull) begin
            strobe.clrReq = 1'b1;
            stateNxt      = WAIT_ACK_LO;
          end
        end
        WAIT_ACK_LO: begin
          if (!syncAck) stateNxt = IDLE_ASYNC;
        end
        default: stateNxt = IDLE_ASYNC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= IDLE_ASYNC;
    else        state <= stateNxt;
  end

  // R2: sub-full programming never starts a handshake
  assert_low_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE_ASYNC && !emuMode && !progFull) |=> state == IDLE_ASYNC);

  // R3: no request before the clock generator confirms full and synced
  assert_wait_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT_LEVEL && !emuMode && !clockReady) |=> state == WAIT_LEVEL);

  // R6: entry cannot be abandoned before acknowledge
  assert_hold_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT_ACK_HI && !emuMode && !syncAck) |=> state == WAIT_ACK_HI);

  // R5: exit waits for acknowledge low
  assert_hold_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT_ACK_LO && !emuMode && syncAck) |=> state == WAIT_ACK_LO);

  assert_one_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.loadProg, strobe.loadFull}));

endmodule

// File: rtl/sms_dpath.sv
module sms_dpath
  import sms_pkg::*;
#(
  parameter int              LVL_W     = 3,
  parameter logic [LVL_W-1:0] RST_LEVEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [LVL_W-1:0] progLevel,
  input  logic             emuMode,
  output logic [LVL_W-1:0] targetLevel,
  output logic             reqOut
);

  localparam logic [LVL_W-1:0] FULL_LVL = {LVL_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      targetLevel <= RST_LEVEL;
    end else if (strobe.loadFull) begin
      targetLevel <= FULL_LVL;
    end else if (strobe.loadProg) begin
      targetLevel <= progLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             reqOut <= 1'b0;
    else if (strobe.clrReq) reqOut <= 1'b0;
    else if (strobe.setReq) reqOut <= 1'b1;
  end

  // R3: request only ever high with a full target
  assert_req_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reqOut |-> targetLevel == FULL_LVL);

  // R7: emulation forces request low
  assert_emu_req_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(emuMode) |-> !reqOut);

endmodule

// File: rtl/sync_mode_sequencer.sv
module sync_mode_sequencer
  import sms_pkg::*;
#(
  parameter int              LVL_W     = 3,
  parameter logic [LVL_W-1:0] RST_LEVEL = 3'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] progLevel,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             clkSynced,
  input  logic             syncAck,
  input  logic             emuMode,
  output logic [LVL_W-1:0] targetLevel,
  output logic             syncReq
);

  dpStrobe_t strobe;

  sms_ctrl #(.LVL_W(LVL_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .progLevel  (progLevel),
    .curLevel   (curLevel),
    .targetLevel(targetLevel),
    .clkSynced  (clkSynced),
    .syncAck    (syncAck),
    .emuMode    (emuMode),
    .strobe     (strobe)
  );

  sms_dpath #(.LVL_W(LVL_W), .RST_LEVEL(RST_LEVEL)) i_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .progLevel  (progLevel),
    .emuMode    (emuMode),
    .targetLevel(targetLevel),
    .reqOut     (syncReq)
  );

  // R4: a raised request is held until acknowledged
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (syncReq && !syncAck && !emuMode) |=> syncReq);

endmodule

// File: tb/test_sync_mode_sequencer.sv
module test_sync_mode_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] RST_LEVEL = 3'd3;
  localparam logic [LVL_W-1:0] FULL = 3'd7;
  localparam int NBR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] progLevel = RST_LEVEL;
  logic [LVL_W-1:0] curLevel = RST_LEVEL;
  logic clkSynced = 1'b0;
  logic syncAck;
  logic emuMode = 1'b0;
  logic [LVL_W-1:0] targetLevel;
  logic syncReq;

  logic [NBR-1:0] ackB = '0;
  logic tieHigh = 1'b0;
  logic holdAck = 1'b0;
  assign syncAck = tieHigh | (&ackB);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int mSt = 0;
  logic [LVL_W-1:0] mT = RST_LEVEL;
  logic mR = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_mode_sequencer #(.LVL_W(LVL_W), .RST_LEVEL(RST_LEVEL)) i_sync_mode_sequencer (
    .clk(clk), .rst_n(rst_n), .progLevel(progLevel), .curLevel(curLevel),
    .clkSynced(clkSynced), .syncAck(syncAck), .emuMode(emuMode),
    .targetLevel(targetLevel), .syncReq(syncReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // phases: 0 async, 1 wait level, 2 wait ack high, 3 sync, 4 wait ack low
  function automatic void modelStep();
    if (!rst_n) begin
      mSt = 0; mT = RST_LEVEL; mR = 1'b0;
    end else if (emuMode) begin
      if (mSt == 0 && progLevel != mT) mT = progLevel;
      mR = 1'b0; mSt = 0;
    end else begin
      case (mSt)
        0: if (progLevel == FULL) begin mT = FULL; mSt = 1; end
           else if (progLevel != mT) mT = progLevel;
        1: if (curLevel == FULL && clkSynced) begin mR = 1'b1; mSt = 2; end
        2: if (syncAck) mSt = 3;
        3: if (progLevel != FULL) begin mR = 1'b0; mSt = 4; end
        4: if (!syncAck) mSt = 0;
        default: mSt = 0;
      endcase
    end
  endfunction

  // bridges and clock generator
  task automatic envStep();
    for (int b = 0; b < NBR; b++)
      if (!holdAck && ackB[b] != syncReq && ($urandom_range(0, b + 1) == 0))
        ackB[b] = syncReq;
    if (curLevel != targetLevel) begin
      clkSynced = 1'b0;
      if ($urandom_range(0, 1) == 0) curLevel = targetLevel;
    end else if (curLevel == FULL && $urandom_range(0, 1) == 0) begin
      clkSynced = 1'b1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    envStep();
    @(negedge clk);
    check("R2 R3 R5 target vs model", targetLevel, mT);
    check("R4 R6 R7 request vs model", syncReq, mR);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset target", targetLevel, RST_LEVEL);
    check("R1 reset request", syncReq, 0);

    // R2: low-level change
    progLevel = 3'd2;
    tick();
    check("R2 low level direct", targetLevel, 2);
    check("R2 request untouched", syncReq, 0);
    repeat (4) tick();

    // R3: entry, target first
    progLevel = FULL;
    tick();
    check("R3 R9 target full first", targetLevel, FULL);
    check("R3 request still low", syncReq, 0);
    holdAck = 1'b1;
    for (int i = 0; i < 50 && !syncReq; i++) tick();
    check("R3 request raised", syncReq, 1);
    // R6: reduction mid-entry
    progLevel = 3'd1;
    ackB = 3'b011;  // one bridge still low
    repeat (5) begin
      tick();
      check("R6 R9 request held one bridge low", syncReq, 1);
      check("R6 target held full", targetLevel, FULL);
    end
    holdAck = 1'b0;
    for (int i = 0; i < 50 && syncReq; i++) tick();
    check("R5 request dropped", syncReq, 0);
    check("R5 target full while ack high", targetLevel, FULL);
    for (int i = 0; i < 50 && targetLevel == FULL; i++) tick();
    check("R5 lower target after exit", targetLevel, 1);
    check("R5 final ack low", syncAck, 0);

    // R7 R8: emulation with tied-high ack
    emuMode = 1'b1;
    tieHigh = 1'b1;
    progLevel = FULL;
    repeat (2) tick();
    check("R7 emu target full", targetLevel, FULL);
    check("R8 emu request low with ack high", syncReq, 0);
    progLevel = 3'd4;
    tick();
    check("R8 emu target follows", targetLevel, 4);
    tieHigh = 1'b0;
    emuMode = 1'b0;
    repeat (10) tick();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 7) == 0)
        progLevel = ($urandom_range(0, 4) < 2) ? FULL : LVL_W'($urandom_range(0, 6));
      if (c == 2000) emuMode = 1'b1;
      if (c == 2200) tieHigh = 1'b1;
      if (c == 2500) tieHigh = 1'b0;
      if (c == 2700) emuMode = 1'b0;
      tick();
    end
    finishRun();
  end

endmodule